// File: doc/BRIEF.md
# System Clock Source Switch Controller

This control block decides which of four clock sources drives the system clock: a multi-speed internal oscillator, a high-speed internal oscillator, a high-speed external oscillator and a main PLL. Software writes a source request. It sets and clears oscillator enables through pulse inputs. Each source reports a ready flag. A request is recorded at once, but the active source moves only when the target is both enabled and ready. Until then the switch stays pending and completes by itself as soon as the target comes up.

A clock-security monitor watches for a failure of the external oscillator. When security is on, and the external oscillator feeds the system clock either directly or through the PLL, a failure forces the active source and the request to the high-speed internal oscillator. The monitor also turns that oscillator on and sets a sticky flag. The flag, gated by an interrupt enable, drives a non-maskable event output. A clear of the enable of any oscillator that feeds the system clock is refused, and an error pulse reports the refusal. All clocks are modelled as ready and failure levels in one control clock domain.

Top module: `clk_src_switch`

## Requirements
- R1: After reset the active source is 00, the request is 00, only enable bit 0 is set (`osc_en` = 0001), and `sw_pending`, `css_flag`, `css_nmi` and `dis_err` are all low.
- R2: Source codes are 00 multi-speed internal, 01 high-speed internal, 10 high-speed external and 11 PLL, and enable and ready bit i belong to code i. A `req_wr` pulse stores `req_sel` at the next edge. The active source `sys_src` takes the stored request one edge later if that target is ready.
- R3: `sw_pending` is high whenever the stored request differs from `sys_src`. A request for a target that is not ready stays pending. It completes at the first edge where the target is ready.
- R4: A source counts as ready only when both its enable bit and its `src_rdy` bit are high.
- R5: When `css_en` and `ext_fail` are high at an edge, and the active source is 10, or is 11 with `pll_from_ext` high, then after that edge `sys_src` is 01, the stored request is 01, and enable bit 1 is set.
- R6: `ext_fail` has no effect when `css_en` is low, or when the external oscillator does not feed the system clock.
- R7: A fallback sets `css_flag`. The flag stays set until a `flag_clr` pulse, and a fallback in the same cycle wins over the clear. `css_nmi` equals `css_flag` AND `css_ie`.
- R8: After a fallback the block does not return to the external source when it recovers, unless software writes a new request.
- R9: `en_set` and `en_clr` change the enable bits at the next edge. A clear wins over a set of the same bit.
- R10: A clear of an enable bit that feeds the system clock is ignored, and `dis_err` pulses for one cycle after that edge. The protected bits are the active source, bit 2 while the PLL is active with `pll_from_ext` high, and the target of a switch taking place at that same edge.
- R11: A fallback takes priority over a `req_wr` in the same cycle. The request ends at 01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | control clock |
| rst_n | input | 1 | asynchronous active-low reset |
| req_wr | input | 1 | request write strobe |
| req_sel | input | 2 | requested source code |
| src_rdy | input | 4 | per-source ready flags |
| en_set | input | 4 | per-source enable set pulses |
| en_clr | input | 4 | per-source enable clear pulses |
| pll_from_ext | input | 1 | PLL reference is the external oscillator |
| css_en | input | 1 | clock-security enable |
| css_ie | input | 1 | security interrupt enable |
| ext_fail | input | 1 | external oscillator failure detected |
| flag_clr | input | 1 | write-one-to-clear for the security flag |
| sys_src | output | 2 | source currently driving the system clock |
| sw_pending | output | 1 | request differs from the active source |
| osc_en | output | 4 | oscillator enable state |
| css_flag | output | 1 | sticky security fallback flag |
| css_nmi | output | 1 | non-maskable security event |
| dis_err | output | 1 | refused-disable error pulse |

## Verification
The bench targets the following corner cases:
- A target that is enabled but not ready. A design that treats the enable alone as ready would switch onto a dead clock.
- A PLL fed from the external oscillator. This case needs both the fallback and the protection of bit 2, and a design that looks only at code 10 misses both.
- A fallback that coincides with a request write. A design that gives the write priority would leave the external source requested and drift back onto it. A design that ignores the protection of the switch target would end with an active source whose enable is off.
- A clear and a set of the same bit in one cycle, and a flag clear in the same cycle as a fresh fallback. Each of these checks the stated priority.

// File: rtl/clksw_pkg.sv
package clksw_pkg;
  localparam int SRC_W = 2;
  localparam int NSRC  = 1 << SRC_W;

  typedef enum logic [SRC_W-1:0] {
    SRC_MSI = 2'd0,
    SRC_HSI = 2'd1,
    SRC_HSE = 2'd2,
    SRC_PLL = 2'd3
  } src_e;

  localparam logic [SRC_W-1:0] RESET_SRC    = SRC_MSI;
  localparam logic [SRC_W-1:0] FALLBACK_SRC = SRC_HSI;
  localparam logic [SRC_W-1:0] EXT_SRC      = SRC_HSE;
  localparam logic [SRC_W-1:0] PLL_SRC      = SRC_PLL;

  // Oscillators whose clock reaches the system when source s is active.
  function automatic logic [NSRC-1:0] feed_mask(logic [SRC_W-1:0] s, logic pll_ext);
    logic [NSRC-1:0] m;
    m = '0;
    m[s] = 1'b1;
    if (s == PLL_SRC && pll_ext) m[EXT_SRC] = 1'b1;
    return m;
  endfunction

  function automatic logic ext_in_use(logic [SRC_W-1:0] s, logic pll_ext);
    return feed_mask(s, pll_ext)[EXT_SRC];
  endfunction

  function automatic logic [NSRC-1:0] onehot(logic [SRC_W-1:0] s);
    logic [NSRC-1:0] m;
    m = '0;
    m[s] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/clksw_osc_enables.sv
module clksw_osc_enables
  import clksw_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] en_set,
  input  logic [NSRC-1:0] en_clr,
  input  logic [NSRC-1:0] protect,
  input  logic            force_fb,
  output logic [NSRC-1:0] en_q,
  output logic            dis_err
);
  logic [NSRC-1:0] clr_ok;
  logic [NSRC-1:0] en_d;

  assign clr_ok = en_clr & ~protect;

  always_comb begin
    en_d = (en_q | en_set) & ~clr_ok;
    if (force_fb) en_d = en_d | onehot(FALLBACK_SRC);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= onehot(RESET_SRC);
      dis_err <= 1'b0;
    end else begin
      en_q    <= en_d;
      dis_err <= |(en_clr & protect);
    end
  end
endmodule

// File: rtl/clksw_src_sel.sv
module clksw_src_sel
  import clksw_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_wr,
  input  logic [SRC_W-1:0] req_sel,
  input  logic [NSRC-1:0]  osc_en,
  input  logic [NSRC-1:0]  src_rdy,
  input  logic             fallback,
  output logic [SRC_W-1:0] sys_src,
  output logic [SRC_W-1:0] req_q,
  output logic             switch_evt,
  output logic             req_ready
);
  logic [NSRC-1:0] usable;

  assign usable     = osc_en & src_rdy;
  assign req_ready  = usable[req_q];
  assign switch_evt = !fallback && (req_q != sys_src) && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sys_src <= RESET_SRC;
      req_q   <= RESET_SRC;
    end else begin
      if (fallback) begin
        sys_src <= FALLBACK_SRC;
        req_q   <= FALLBACK_SRC;
      end else begin
        if (switch_evt) sys_src <= req_q;
        if (req_wr)     req_q   <= req_sel;
      end
    end
  end
endmodule

// File: rtl/clksw_css_mon.sv
module clksw_css_mon
  import clksw_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             css_en,
  input  logic             css_ie,
  input  logic             ext_fail,
  input  logic             pll_ext,
  input  logic [SRC_W-1:0] sys_src,
  input  logic             flag_clr,
  output logic             fallback,
  output logic             css_flag,
  output logic             css_nmi
);
  assign fallback = css_en && ext_fail && ext_in_use(sys_src, pll_ext);
  assign css_nmi  = css_flag && css_ie;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        css_flag <= 1'b0;
    else if (fallback) css_flag <= 1'b1;
    else if (flag_clr) css_flag <= 1'b0;
  end
endmodule

// File: rtl/clk_src_switch.sv
module clk_src_switch
  import clksw_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_wr,
  input  logic [SRC_W-1:0] req_sel,
  input  logic [NSRC-1:0]  src_rdy,
  input  logic [NSRC-1:0]  en_set,
  input  logic [NSRC-1:0]  en_clr,
  input  logic             pll_from_ext,
  input  logic             css_en,
  input  logic             css_ie,
  input  logic             ext_fail,
  input  logic             flag_clr,
  output logic [SRC_W-1:0] sys_src,
  output logic             sw_pending,
  output logic [NSRC-1:0]  osc_en,
  output logic             css_flag,
  output logic             css_nmi,
  output logic             dis_err
);
  // named internal events, visible to the checker
  logic             fallback_evt;
  logic             switch_evt;
  logic             req_ready;
  logic [SRC_W-1:0] req_q;
  logic [NSRC-1:0]  protect;

  assign protect = feed_mask(sys_src, pll_from_ext)
                 | (switch_evt ? feed_mask(req_q, pll_from_ext) : '0);
  assign sw_pending = (req_q != sys_src);

  clksw_css_mon u_css (
    .clk(clk), .rst_n(rst_n), .css_en(css_en), .css_ie(css_ie),
    .ext_fail(ext_fail), .pll_ext(pll_from_ext), .sys_src(sys_src),
    .flag_clr(flag_clr), .fallback(fallback_evt), .css_flag(css_flag),
    .css_nmi(css_nmi)
  );

  clksw_src_sel u_sel (
    .clk(clk), .rst_n(rst_n), .req_wr(req_wr), .req_sel(req_sel),
    .osc_en(osc_en), .src_rdy(src_rdy), .fallback(fallback_evt),
    .sys_src(sys_src), .req_q(req_q), .switch_evt(switch_evt),
    .req_ready(req_ready)
  );

  clksw_osc_enables u_en (
    .clk(clk), .rst_n(rst_n), .en_set(en_set), .en_clr(en_clr),
    .protect(protect), .force_fb(fallback_evt), .en_q(osc_en),
    .dis_err(dis_err)
  );
endmodule

// File: rtl/clk_src_switch_chk.sv
module clk_src_switch_chk
  import clksw_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             css_en,
  input logic             flag_clr,
  input logic [NSRC-1:0]  en_clr,
  input logic [SRC_W-1:0] sys_src,
  input logic [NSRC-1:0]  osc_en,
  input logic             css_flag,
  input logic             css_nmi,
  input logic             dis_err,
  input logic             fallback_evt,
  input logic             switch_evt,
  input logic             req_ready,
  input logic [SRC_W-1:0] req_q,
  input logic [NSRC-1:0]  protect
);
  // R5
  fallback_to_hsi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fallback_evt |=> (sys_src == FALLBACK_SRC && req_q == FALLBACK_SRC && osc_en[FALLBACK_SRC]));

  // R3
  hold_unready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!fallback_evt && !req_ready) |=> (sys_src == $past(sys_src)));

  // R2
  switch_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    switch_evt |=> (sys_src == $past(req_q)));

  // R10
  active_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    osc_en[sys_src]);

  // R10
  dis_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(en_clr & protect)) |=> dis_err);

  // R7
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (css_flag && !flag_clr) |=> css_flag);

  // R7
  nmi_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    css_nmi |-> css_flag);

  // R6
  no_fallback_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !css_en |-> !fallback_evt);
endmodule

bind clk_src_switch clk_src_switch_chk chk_i (
  .clk(clk), .rst_n(rst_n), .css_en(css_en), .flag_clr(flag_clr),
  .en_clr(en_clr), .sys_src(sys_src), .osc_en(osc_en), .css_flag(css_flag),
  .css_nmi(css_nmi), .dis_err(dis_err), .fallback_evt(fallback_evt),
  .switch_evt(switch_evt), .req_ready(req_ready), .req_q(req_q),
  .protect(protect)
);

// File: tb/clk_src_switch_tb_top.sv
module clk_src_switch_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_wr = 1'b0;
  logic [1:0] req_sel = 2'd0;
  logic [3:0] src_rdy = 4'b0001;
  logic [3:0] en_set = 4'd0;
  logic [3:0] en_clr = 4'd0;
  logic       pll_from_ext = 1'b0;
  logic       css_en = 1'b0;
  logic       css_ie = 1'b0;
  logic       ext_fail = 1'b0;
  logic       flag_clr = 1'b0;
  logic [1:0] sys_src;
  logic       sw_pending;
  logic [3:0] osc_en;
  logic       css_flag;
  logic       css_nmi;
  logic       dis_err;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  clk_src_switch dut_i (
    .clk(clk), .rst_n(rst_n), .req_wr(req_wr), .req_sel(req_sel),
    .src_rdy(src_rdy), .en_set(en_set), .en_clr(en_clr),
    .pll_from_ext(pll_from_ext), .css_en(css_en), .css_ie(css_ie),
    .ext_fail(ext_fail), .flag_clr(flag_clr), .sys_src(sys_src),
    .sw_pending(sw_pending), .osc_en(osc_en), .css_flag(css_flag),
    .css_nmi(css_nmi), .dis_err(dis_err)
  );

  // reference model state
  int  m_src, m_req;
  bit  m_en[4];
  bit  m_flag, m_err;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_src = 0; m_req = 0; m_flag = 0; m_err = 0;
      foreach (m_en[i]) m_en[i] = (i == 0);
    end else begin
      bit fb, sw, hit;
      bit guard[4];
      int n_src, n_req;
      fb = css_en && ext_fail && (m_src == 2 || (m_src == 3 && pll_from_ext));
      sw = !fb && (m_req != m_src) && m_en[m_req] && src_rdy[m_req];
      foreach (guard[i]) guard[i] = 0;
      guard[m_src] = 1;
      if (m_src == 3 && pll_from_ext) guard[2] = 1;
      if (sw) begin
        guard[m_req] = 1;
        if (m_req == 3 && pll_from_ext) guard[2] = 1;
      end
      hit = 0;
      for (int i = 0; i < 4; i++) begin
        if (en_clr[i] && guard[i]) hit = 1;
        if (en_clr[i] && !guard[i]) m_en[i] = 0;
        else if (en_set[i]) m_en[i] = 1;
      end
      if (fb) m_en[1] = 1;
      m_err = hit;
      n_src = fb ? 1 : (sw ? m_req : m_src);
      n_req = fb ? 1 : (req_wr ? int'(req_sel) : m_req);
      m_src = n_src; m_req = n_req;
      if (fb) m_flag = 1;
      else if (flag_clr) m_flag = 0;
    end
  end

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison with the model
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      int men;
      men = 0;
      for (int i = 0; i < 4; i++) men |= int'(m_en[i]) << i;
      chk("R2 sys_src", sys_src, m_src);
      chk("R3 sw_pending", sw_pending, int'(m_req != m_src));
      chk("R9 osc_en", osc_en, men);
      chk("R7 css_flag", css_flag, m_flag);
      chk("R7 css_nmi", css_nmi, int'(m_flag && css_ie));
      chk("R10 dis_err", dis_err, m_err);
    end
  end

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_req(logic [1:0] s);
    req_sel = s; req_wr = 1'b1;
    tick();
    req_wr = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog act=timeout exp=done");
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick();
    // R1 reset state
    chk("R1 src", sys_src, 0);
    chk("R1 en", osc_en, 4'b0001);
    chk("R1 pend", sw_pending, 0);
    chk("R1 flag", css_flag, 0);
    chk("R1 nmi", css_nmi, 0);
    chk("R1 err", dis_err, 0);

    // R3 request for a source that is off
    write_req(2'd2);
    tick(2);
    chk("R3 pending", sw_pending, 1);
    chk("R3 hold", sys_src, 0);

    // R4 enabled but not ready
    en_set = 4'b0100; tick(); en_set = 4'd0;
    tick(2);
    chk("R4 not ready", sys_src, 0);
    src_rdy = 4'b1111;
    tick();
    chk("R3 auto switch", sys_src, 2);
    chk("R3 pend clear", sw_pending, 0);

    // R10 refuse disabling the active source
    en_clr = 4'b0100; tick(); en_clr = 4'd0;
    chk("R10 err", dis_err, 1);
    chk("R10 kept", osc_en[2], 1);
    tick();
    chk("R10 pulse", dis_err, 0);

    // R5 security fallback
    css_en = 1'b1; css_ie = 1'b1; ext_fail = 1'b1;
    tick(); ext_fail = 1'b0;
    chk("R5 src", sys_src, 1);
    chk("R5 hsi on", osc_en[1], 1);
    chk("R7 flag", css_flag, 1);
    chk("R7 nmi", css_nmi, 1);
    tick(5);
    chk("R8 no return", sys_src, 1);
    chk("R7 sticky", css_flag, 1);
    flag_clr = 1'b1; tick(); flag_clr = 1'b0;
    chk("R7 cleared", css_flag, 0);

    // R6 security off
    css_en = 1'b0;
    write_req(2'd2); tick();
    chk("R8 new req", sys_src, 2);
    ext_fail = 1'b1; tick(2); ext_fail = 1'b0;
    chk("R6 no fallback", sys_src, 2);
    chk("R6 no flag", css_flag, 0);

    // PLL fed from external
    pll_from_ext = 1'b1;
    en_set = 4'b1000; tick(); en_set = 4'd0;
    write_req(2'd3); tick();
    chk("R2 pll", sys_src, 3);
    en_clr = 4'b0100; tick(); en_clr = 4'd0;
    chk("R10 pll ext err", dis_err, 1);
    chk("R10 pll ext kept", osc_en[2], 1);

    // R11 fallback beats request write
    css_en = 1'b1; ext_fail = 1'b1;
    req_sel = 2'd0; req_wr = 1'b1;
    tick(); req_wr = 1'b0; ext_fail = 1'b0;
    chk("R11 src", sys_src, 1);
    chk("R11 pend", sw_pending, 0);

    // R9 enable priority
    en_clr = 4'b0001; tick(); en_clr = 4'd0;
    chk("R9 clr", osc_en[0], 0);
    chk("R9 no err", dis_err, 0);
    en_set = 4'b0001; en_clr = 4'b0001; tick(); en_set = 4'd0; en_clr = 4'd0;
    chk("R9 clr wins", osc_en[0], 0);
    en_set = 4'b0001; tick(); en_set = 4'd0;
    chk("R9 set", osc_en[0], 1);

    // random traffic, checked against the model every cycle
    for (int k = 0; k < 3000; k++) begin
      req_wr       = ($urandom_range(0, 3) == 0);
      req_sel      = 2'($urandom_range(0, 3));
      src_rdy      = 4'($urandom_range(0, 15));
      en_set       = ($urandom_range(0, 2) == 0) ? 4'($urandom_range(0, 15)) : 4'd0;
      en_clr       = ($urandom_range(0, 3) == 0) ? 4'($urandom_range(0, 15)) : 4'd0;
      pll_from_ext = ($urandom_range(0, 1) == 1);
      css_en       = ($urandom_range(0, 3) != 0);
      css_ie       = ($urandom_range(0, 1) == 1);
      ext_fail     = ($urandom_range(0, 15) == 0);
      flag_clr     = ($urandom_range(0, 7) == 0);
      tick();
    end
    req_wr = 0; en_set = 0; en_clr = 0; ext_fail = 0; flag_clr = 0;
    tick(2);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule